// File: doc/BRIEF.md
# Dual-Threshold Bit-Error-Rate Alarm Monitor

This block consumes one parity error count per received frame and decides whether the line is degraded or failing. It runs two identical channels, degrade and fail. Each channel has its own window length in frames, its own set threshold, clear threshold and decrement value. Per-frame counts arrive on one of two error inputs, section-level or line-level, picked by a select input. A frame strobe qualifies each count.

A global mode input chooses between two algorithms for both channels. In leaky-bucket mode errors accumulate across windows. At each window end the total is compared against the thresholds and then drained by the decrement value, so the alarm shows hysteresis. In rate mode each window is judged on its own count alone.

Every alarm transition, whether assertion or removal, sets a sticky status bit. The status bits feed a maskable interrupt. A configuration input decides whether software clears the status bits with a read strobe or with a write of ones. While the upstream framer reports loss of signal or frame, monitoring pauses and the window state restarts.

Top module: `ber_alarm_mon`

## Requirements
- R1: While reset is low, and on the first cycle after it, both alarms, both status bits and the interrupt are 0.
- R2: With `src_line`=0 the count on `sec_err` is used. With `src_line`=1 the count on `line_err` is used. The other input has no effect.
- R3: Only cycles with `frm_stb`=1 advance a window. A window ends on its Nth strobe, where N is the channel's window length and a length of 0 acts as 1. An alarm changes only in the cycle after a window-ending strobe.
- R4: Leaky mode: at a window end, the sum S is the accumulated count plus the current frame's count. If S is at or above the set threshold, the alarm is 1 from the next cycle.
- R5: Leaky mode: after the compare, S minus the decrement value is stored, saturating at 0. The accumulator saturates at 524287 and does not wrap.
- R6: Leaky mode: an active alarm clears at a window end where S is below the clear threshold. It stays set while S lies between the clear and set thresholds.
- R7: Rate mode (`rate_mode`=1): the alarm after each window end equals (S ≥ set threshold). The accumulator restarts at 0, and the clear threshold and decrement have no effect.
- R8: Every alarm transition sets its sticky status bit in the same cycle: bit 0 for degrade, bit 1 for fail. Status bits rise for no other reason.
- R9: `irq` is 1 exactly when some status bit is 1 and the `irq_mask` bit at the same position is 0.
- R10: With `clr_on_rd`=0, `stat_wr` clears each status bit whose `stat_wdata` bit is 1, and `stat_rd` has no effect.
- R11: With `clr_on_rd`=1, `stat_rd` clears both status bits and `stat_wr` has no effect. An alarm transition in the same cycle leaves its bit set.
- R12: While `sync_lost`=1, strobes are ignored, the window count and accumulator reset to 0, and the alarms hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_stb | input | 1 | One-cycle strobe per received frame |
| sec_err | input | 12 | Section-level parity error count of the frame |
| line_err | input | 12 | Line-level parity error count of the frame |
| src_line | input | 1 | Error source select, 1 = line-level |
| sync_lost | input | 1 | Loss of signal/frame or errored-frame alarm from the framer |
| rate_mode | input | 1 | 0 = leaky bucket, 1 = rate detection |
| deg_win | input | 20 | Degrade window length in frames |
| deg_set | input | 19 | Degrade set threshold |
| deg_clr | input | 19 | Degrade clear threshold |
| deg_dec | input | 15 | Degrade per-window decrement |
| fail_win | input | 20 | Fail window length in frames |
| fail_set | input | 19 | Fail set threshold |
| fail_clr | input | 19 | Fail clear threshold |
| fail_dec | input | 15 | Fail per-window decrement |
| clr_on_rd | input | 1 | Status clear policy, 1 = on read |
| stat_rd | input | 1 | Status register read strobe |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 2 | Write data, ones clear status bits |
| irq_mask | input | 2 | Interrupt mask, 1 = masked |
| status | output | 2 | Sticky transition status |
| irq | output | 1 | Interrupt request |
| deg_alarm | output | 1 | Signal degrade alarm |
| fail_alarm | output | 1 | Signal fail alarm |

## Verification
The checker watches several rules on every cycle. An alarm never moves without a window-ending strobe or while sync is lost. Every alarm transition is mirrored in its status bit. A status bit rises only on such a transition and falls only under the clear strobe that the current policy permits. The bench's scenarios are needed for the rest: the arithmetic outcomes such as thresholds at equality, hysteresis between the two thresholds, saturation at both ends, rate-mode restarts and source selection, plus the priority of an event over a same-cycle read. They run against a behavioural model compared on every clock.

// File: rtl/ber_mon_pkg.sv
package ber_mon_pkg;
   typedef enum logic {
      MODE_LEAKY = 1'b0,
      MODE_RATE  = 1'b1
   } ber_mode_e;

   localparam int N_CH    = 2;
   localparam int CH_DEG  = 0;
   localparam int CH_FAIL = 1;
endpackage

// File: rtl/ber_chan.sv
module ber_chan
   import ber_mon_pkg::*;
#(
   parameter int ERRW = 12,
   parameter int ACCW = 19,
   parameter int WINW = 20,
   parameter int DECW = 15
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sync_lost,
   input  logic            frm_stb,
   input  ber_mode_e       mode,
   input  logic [ERRW-1:0] err,
   input  logic [WINW-1:0] win_len,
   input  logic [ACCW-1:0] set_th,
   input  logic [ACCW-1:0] clr_th,
   input  logic [DECW-1:0] dec_val,
   output logic            alarm,
   output logic            evt
);
   localparam int SUMW = ACCW + 1;

   logic [ACCW-1:0] acc_q, acc_d, sum, dec_ext;
   logic [SUMW-1:0] sum_w;
   logic [WINW-1:0] wcnt_q, wcnt_d, last_idx;
   logic            win_end, alarm_q, alarm_d;

   always_comb begin
      sum_w    = SUMW'(acc_q) + SUMW'(err);
      sum      = sum_w[ACCW] ? {ACCW{1'b1}} : sum_w[ACCW-1:0];
      dec_ext  = ACCW'(dec_val);
      last_idx = (win_len == '0) ? '0 : win_len - WINW'(1);
      win_end  = frm_stb && !sync_lost && (wcnt_q >= last_idx);

      alarm_d = alarm_q;
      if (win_end) begin
         if (mode == MODE_RATE)
            alarm_d = (sum >= set_th);
         else if (alarm_q)
            alarm_d = !(sum < clr_th);
         else
            alarm_d = (sum >= set_th);
      end

      if (sync_lost) begin
         acc_d  = '0;
         wcnt_d = '0;
      end else if (!frm_stb) begin
         acc_d  = acc_q;
         wcnt_d = wcnt_q;
      end else if (!win_end) begin
         acc_d  = sum;
         wcnt_d = wcnt_q + WINW'(1);
      end else begin
         wcnt_d = '0;
         if (mode == MODE_RATE)
            acc_d = '0;
         else
            acc_d = (sum > dec_ext) ? sum - dec_ext : '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q   <= '0;
         wcnt_q  <= '0;
         alarm_q <= 1'b0;
      end else begin
         acc_q   <= acc_d;
         wcnt_q  <= wcnt_d;
         alarm_q <= alarm_d;
      end
   end

   assign alarm = alarm_q;
   assign evt   = win_end && (alarm_d != alarm_q);
endmodule

// File: rtl/ber_status.sv
module ber_status #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic         clr_on_rd,
   input  logic         rd,
   input  logic         wr,
   input  logic [N-1:0] wdata,
   input  logic [N-1:0] mask,
   output logic [N-1:0] status,
   output logic         irq
);
   logic [N-1:0] st_q, clr_vec;

   always_comb begin
      if (clr_on_rd)
         clr_vec = {N{rd}};
      else
         clr_vec = wr ? wdata : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         st_q <= '0;
      else
         st_q <= evt | (st_q & ~clr_vec);
   end

   assign status = st_q;
   assign irq    = |(st_q & ~mask);
endmodule

// File: rtl/ber_alarm_mon.sv
module ber_alarm_mon
   import ber_mon_pkg::*;
#(
   parameter int ERRW = 12,
   parameter int ACCW = 19,
   parameter int WINW = 20,
   parameter int DECW = 15
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            frm_stb,
   input  logic [ERRW-1:0] sec_err,
   input  logic [ERRW-1:0] line_err,
   input  logic            src_line,
   input  logic            sync_lost,
   input  logic            rate_mode,
   input  logic [WINW-1:0] deg_win,
   input  logic [ACCW-1:0] deg_set,
   input  logic [ACCW-1:0] deg_clr,
   input  logic [DECW-1:0] deg_dec,
   input  logic [WINW-1:0] fail_win,
   input  logic [ACCW-1:0] fail_set,
   input  logic [ACCW-1:0] fail_clr,
   input  logic [DECW-1:0] fail_dec,
   input  logic            clr_on_rd,
   input  logic            stat_rd,
   input  logic            stat_wr,
   input  logic [1:0]      stat_wdata,
   input  logic [1:0]      irq_mask,
   output logic [1:0]      status,
   output logic            irq,
   output logic            deg_alarm,
   output logic            fail_alarm
);
   if (ERRW > ACCW) begin : g_bad_errw
      $error("ERRW must not exceed ACCW");
   end
   if (DECW > ACCW) begin : g_bad_decw
      $error("DECW must not exceed ACCW");
   end
   if (WINW < 1) begin : g_bad_winw
      $error("WINW must be at least 1");
   end

   logic [ERRW-1:0] err_sel;
   ber_mode_e       mode;
   logic [WINW-1:0] win_a [N_CH];
   logic [ACCW-1:0] set_a [N_CH];
   logic [ACCW-1:0] clr_a [N_CH];
   logic [DECW-1:0] dec_a [N_CH];
   logic [N_CH-1:0] alarm_v, evt_v;

   assign err_sel = src_line ? line_err : sec_err;
   assign mode    = ber_mode_e'(rate_mode);

   assign win_a[CH_DEG]  = deg_win;
   assign set_a[CH_DEG]  = deg_set;
   assign clr_a[CH_DEG]  = deg_clr;
   assign dec_a[CH_DEG]  = deg_dec;
   assign win_a[CH_FAIL] = fail_win;
   assign set_a[CH_FAIL] = fail_set;
   assign clr_a[CH_FAIL] = fail_clr;
   assign dec_a[CH_FAIL] = fail_dec;

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      ber_chan #(
         .ERRW(ERRW), .ACCW(ACCW), .WINW(WINW), .DECW(DECW)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .sync_lost(sync_lost),
         .frm_stb  (frm_stb),
         .mode     (mode),
         .err      (err_sel),
         .win_len  (win_a[c]),
         .set_th   (set_a[c]),
         .clr_th   (clr_a[c]),
         .dec_val  (dec_a[c]),
         .alarm    (alarm_v[c]),
         .evt      (evt_v[c])
      );
   end

   ber_status #(.N(N_CH)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_v),
      .clr_on_rd(clr_on_rd),
      .rd       (stat_rd),
      .wr       (stat_wr),
      .wdata    (stat_wdata),
      .mask     (irq_mask),
      .status   (status),
      .irq      (irq)
   );

   assign deg_alarm  = alarm_v[CH_DEG];
   assign fail_alarm = alarm_v[CH_FAIL];
endmodule

// File: rtl/ber_alarm_mon_chk.sv
module ber_alarm_mon_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       frm_stb,
   input logic       sync_lost,
   input logic       clr_on_rd,
   input logic       stat_rd,
   input logic       stat_wr,
   input logic [1:0] stat_wdata,
   input logic [1:0] status,
   input logic       deg_alarm,
   input logic       fail_alarm
);
   AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_stb |=> ($stable(deg_alarm) && $stable(fail_alarm))); // R3

   AST_SYNC_LOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sync_lost |=> ($stable(deg_alarm) && $stable(fail_alarm))); // R12

   AST_DEG_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (deg_alarm != $past(deg_alarm)) |-> status[0]); // R8

   AST_FAIL_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_alarm != $past(fail_alarm)) |-> status[1]); // R8

   AST_DEG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[0]) |-> (deg_alarm != $past(deg_alarm))); // R8

   AST_RD_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(status[0]) && $past(clr_on_rd)) |-> $past(stat_rd)); // R11

   AST_WR_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(status[1]) && !$past(clr_on_rd)) |-> $past(stat_wr && stat_wdata[1])); // R10
endmodule

bind ber_alarm_mon ber_alarm_mon_chk u_chk (.*);

// File: tb/ber_alarm_mon_test.sv
module ber_alarm_mon_test;
   localparam int CLK_PERIOD = 10;
   localparam int ACC_MAX    = 524287;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frm_stb = 1'b0;
   logic [11:0] sec_err = '0, line_err = '0;
   logic        src_line = 1'b0, sync_lost = 1'b0, rate_mode = 1'b0;
   logic [19:0] deg_win = '0, fail_win = '0;
   logic [18:0] deg_set = '0, deg_clr = '0, fail_set = '0, fail_clr = '0;
   logic [14:0] deg_dec = '0, fail_dec = '0;
   logic        clr_on_rd = 1'b0, stat_rd = 1'b0, stat_wr = 1'b0;
   logic [1:0]  stat_wdata = '0, irq_mask = '0;
   logic [1:0]  status;
   logic        irq, deg_alarm, fail_alarm;

   ber_alarm_mon uut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int    n_vec = 0, n_bad = 0;
   string cur_req = "R1";
   bit    done = 0;

   int m_acc [2], m_wc [2], m_al [2], m_st [2];

   function automatic int pick(input int ch, input int a, input int b);
      return (ch == 0) ? a : b;
   endfunction

   always @(posedge clk) begin
      int ev [2];
      if (!rst_n) begin
         for (int c = 0; c < 2; c++) begin
            m_acc[c] = 0; m_wc[c] = 0; m_al[c] = 0; m_st[c] = 0;
         end
      end else begin
         for (int c = 0; c < 2; c++) begin
            int e, s, win, last, na, st_, cl, dc;
            ev[c] = 0;
            win = pick(c, int'(deg_win), int'(fail_win));
            st_ = pick(c, int'(deg_set), int'(fail_set));
            cl  = pick(c, int'(deg_clr), int'(fail_clr));
            dc  = pick(c, int'(deg_dec), int'(fail_dec));
            if (sync_lost) begin
               m_acc[c] = 0; m_wc[c] = 0;
            end else if (frm_stb) begin
               e = src_line ? int'(line_err) : int'(sec_err);
               s = m_acc[c] + e;
               if (s > ACC_MAX) s = ACC_MAX;
               last = (win == 0) ? 0 : win - 1;
               if (m_wc[c] >= last) begin
                  m_wc[c] = 0;
                  if (rate_mode) begin
                     na = (s >= st_) ? 1 : 0;
                     m_acc[c] = 0;
                  end else begin
                     if (m_al[c] == 1) na = (s < cl) ? 0 : 1;
                     else              na = (s >= st_) ? 1 : 0;
                     m_acc[c] = (s > dc) ? s - dc : 0;
                  end
                  ev[c] = (na != m_al[c]) ? 1 : 0;
                  m_al[c] = na;
               end else begin
                  m_wc[c] = m_wc[c] + 1;
                  m_acc[c] = s;
               end
            end
         end
         for (int c = 0; c < 2; c++) begin
            if (ev[c] == 1) m_st[c] = 1;
            else if (clr_on_rd ? stat_rd : (stat_wr && stat_wdata[c])) m_st[c] = 0;
         end
      end
   end

   task automatic cmp(input string what, input int got, input int exp);
      n_vec++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s got %0d expected %0d at %0t", cur_req, what, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      int exp_irq;
      if (!done) begin
         exp_irq = ((m_st[0] == 1 && !irq_mask[0]) || (m_st[1] == 1 && !irq_mask[1])) ? 1 : 0;
         cmp("deg_alarm",  int'(deg_alarm),  m_al[0]);
         cmp("fail_alarm", int'(fail_alarm), m_al[1]);
         cmp("status0",    int'(status[0]),  m_st[0]);
         cmp("status1",    int'(status[1]),  m_st[1]);
         cmp("irq",        int'(irq),        exp_irq);
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic frame(input int s, input int l, input int gap);
      frm_stb = 1'b1; sec_err = 12'(s); line_err = 12'(l);
      tick();
      frm_stb = 1'b0;
      for (int i = 0; i < gap; i++) tick();
   endtask

   task automatic finish_run();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog expired in %s", cur_req);
      finish_run();
   end

   initial begin
      cur_req = "R1";
      for (int i = 0; i < 4; i++) tick();
      rst_n = 1'b1;
      tick();

      cur_req = "R4";
      deg_win = 4; deg_set = 20; deg_clr = 10; deg_dec = 8;
      fail_win = 4; fail_set = 1000; fail_clr = 500; fail_dec = 100;
      for (int i = 0; i < 4; i++) frame(5, 0, 1);
      for (int i = 0; i < 4; i++) frame(6, 0, 1);

      cur_req = "R6";
      for (int i = 0; i < 4; i++) frame(1, 0, 1);
      for (int i = 0; i < 8; i++) frame(0, 0, 1);

      cur_req = "R2";
      src_line = 1'b1;
      for (int i = 0; i < 4; i++) frame(50, 7, 1);
      for (int i = 0; i < 4; i++) frame(0, 0, 1);
      src_line = 1'b0;
      for (int i = 0; i < 4; i++) frame(0, 900, 1);

      cur_req = "R9";
      irq_mask = 2'b01; tick(); tick();
      irq_mask = 2'b11; tick();
      irq_mask = 2'b10; tick();

      cur_req = "R10";
      clr_on_rd = 1'b0;
      stat_rd = 1'b1; tick(); stat_rd = 1'b0; tick();
      stat_wr = 1'b1; stat_wdata = 2'b01; tick(); stat_wr = 1'b0; tick();
      stat_wr = 1'b1; stat_wdata = 2'b11; tick(); stat_wr = 1'b0; tick();

      cur_req = "R5";
      fail_win = 0; fail_set = 19'(ACC_MAX); fail_clr = 1; fail_dec = 0;
      for (int i = 0; i < 140; i++) frame(4095, 0, 0);
      tick();
      fail_dec = 15'h7fff; fail_set = 19'(ACC_MAX);
      for (int i = 0; i < 20; i++) frame(0, 0, 0);
      tick();

      cur_req = "R3";
      deg_win = 3; deg_set = 9; deg_clr = 3; deg_dec = 9;
      frame(3, 0, 0); frame(3, 0, 4); frame(3, 0, 2);
      frame(0, 0, 3); frame(0, 0, 0); frame(0, 0, 5);

      cur_req = "R7";
      rate_mode = 1'b1;
      deg_win = 3; deg_set = 10; deg_clr = 0; deg_dec = 1;
      fail_win = 2; fail_set = 8; fail_clr = 0; fail_dec = 0;
      for (int i = 0; i < 3; i++) frame(4, 0, 1);
      for (int i = 0; i < 3; i++) frame(3, 0, 1);
      for (int i = 0; i < 3; i++) frame(4, 0, 1);
      for (int i = 0; i < 3; i++) frame(4, 0, 1);
      for (int i = 0; i < 6; i++) frame(1, 0, 1);

      cur_req = "R11";
      clr_on_rd = 1'b1; irq_mask = 2'b00;
      stat_wr = 1'b1; stat_wdata = 2'b11; tick(); stat_wr = 1'b0; tick();
      stat_rd = 1'b1; tick(); stat_rd = 1'b0; tick();
      deg_win = 1; deg_set = 5;
      frm_stb = 1'b1; sec_err = 9; stat_rd = 1'b1;
      tick();
      frm_stb = 1'b0; stat_rd = 1'b0; tick(); tick();
      stat_rd = 1'b1; tick(); stat_rd = 1'b0; tick();

      cur_req = "R12";
      rate_mode = 1'b0; clr_on_rd = 1'b0;
      deg_win = 4; deg_set = 12; deg_clr = 2; deg_dec = 2;
      frame(5, 0, 0); frame(5, 0, 0);
      sync_lost = 1'b1;
      for (int i = 0; i < 6; i++) frame(40, 0, 0);
      sync_lost = 1'b0; tick();
      frame(3, 0, 0); frame(3, 0, 0); frame(3, 0, 0); frame(3, 0, 1);
      frame(3, 0, 0); frame(3, 0, 0); frame(3, 0, 0); frame(3, 0, 2);

      cur_req = "R1";
      rst_n = 1'b0; tick(); tick();
      rst_n = 1'b1; tick(); tick();

      finish_run();
   end
endmodule